// File: doc/BRIEF.md
# Flash Command Interface and Write Controller

This block sits in front of a block-erasable flash array, modelled here as a register array, and turns ordinary processor write cycles into array operations. Every alteration takes two writes: a setup code, then a confirm code or the data. Erase clears a whole block, program ANDs new data into one location, and lock configuration sets one block's lock bit or clears all of them. Each operation runs for a set number of cycles, and its progress and outcome are read back through an 8-bit status byte.

The array cannot change while the program-enable input is low, while the supply-lockout flag is high, while reset is asserted, or when the target block is locked. A running erase can be suspended so that other blocks can be read or programmed, and then resumed. The read port returns either array data or the status byte. Array data comes as a 16-bit word, or as a single byte when byte mode is selected.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: An alteration starts only after a two-write sequence: erase is 0x20 then 0xD0, program is 0x40 then the data word, lock is 0x60 then 0x01 (set the lock bit of the addressed block) or 0xD0 (clear every lock bit). A lone 0xD0 or 0x01 written while ready changes neither the array nor the status.
- R2: If the second write after 0x20 or 0x60 is not a valid confirm code, status bits 5 and 4 are set and nothing is altered.
- R3: If program-enable is low or supply-lockout is high when an operation is confirmed or when it completes, the array is unchanged and status bit 3 is set. Bit 5 is also set for an erase or a lock clear; bit 4 is also set for a program or a lock set.
- R4: An erase or program aimed at a locked block is refused, and status bit 1 is set together with bit 5 (erase) or bit 4 (program).
- R5: While reset is low, writes are ignored. An operation cut short by reset leaves its target unchanged. After reset the read mode is array and the status reads 0x80.
- R6: Program takes its address and data on the second write, so bus changes during the busy time have no effect. The stored word becomes old AND new. A byte-mode program fills the other byte lane with 0xFF.
- R7: A completed erase sets every word of the target block to 0xFFFF and leaves the other blocks unchanged.
- R8: Status bit 7 is 0 while an operation runs and 1 otherwise. Any setup code, and 0x70, switch the read port to status, which is returned as {8'h00, status}.
- R9: Command 0x50 clears status bits 5, 4, 3 and 1.
- R10: Writing 0xB0 during an erase pauses it: bit 7 and bit 6 go to 1, and other blocks can then be read and programmed. Writing 0xD0 while suspended clears bit 6 and continues the erase from where it stopped.
- R11: After an operation ends, reads keep returning the status until 0xFF is written.
- R12: Addresses are byte addresses, and the block index is the top BLK_W address bits. In word mode (byte_mode=0), addr[0] is ignored and rdata is the 16-bit word. In byte mode, rdata[7:0] is the low byte when addr[0]=0 and the high byte when addr[0]=1, with rdata[15:8]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also disables all alteration |
| we | input | 1 | Write strobe, one command or data write per cycle |
| addr | input | ADDR_W | Byte address for reads, commands and data |
| wdata | input | 16 | Command code in bits 7:0, or program data |
| byte_mode | input | 1 | 1 selects byte-wide access, 0 selects word-wide |
| vpp_ok | input | 1 | Program-enable level above its lockout threshold |
| vcc_lockout | input | 1 | Supply below the write-lockout level |
| rdata | output | 16 | Array data or status byte, depending on read mode |

## Verification
Nearly every wrong internal state in this block reaches the ports within a few cycles through the status byte. A wrong controller state changes bit 7 or bit 6 on the next status read, and a lost guard leaves an error bit clear when it should be set. Wrong array contents stay hidden until 0xFF is written and that location is read. For this reason each operation is followed by a status read and then an array read of the target and a neighbouring location. A suspend that loses the erase count shows up as an erase that never finishes, or as a block still holding old data after resume.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
   localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
   localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
   localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
   localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
   localparam logic [7:0] CMD_LOCK_SETUP   = 8'h60;
   localparam logic [7:0] CMD_LOCK_SET     = 8'h01;
   localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
   localparam logic [7:0] CMD_SUSPEND      = 8'hB0;

   typedef enum logic [2:0] {
      FS_IDLE, FS_ERASE_SETUP, FS_PROG_SETUP, FS_LOCK_SETUP,
      FS_BUSY_ERASE, FS_BUSY_PROG, FS_BUSY_LOCK
   } fsm_e;

   typedef enum logic {RM_ARRAY, RM_STATUS} rmode_e;
endpackage

// File: rtl/fcc_op_timer.sv
module fcc_op_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= load_val;
      else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign done = run && (cnt_q == CNT_W'(1));

   // R10: a paused operation keeps its remaining time
   a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
   parameter int ADDR_W = 8,
   parameter int BLK_W  = 2,
   parameter int DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-2:0]     rd_widx,
   output logic [DATA_W-1:0]     rd_word,
   input  logic                  prog_en,
   input  logic [ADDR_W-2:0]     prog_widx,
   input  logic [DATA_W-1:0]     prog_mask,
   input  logic                  erase_en,
   input  logic [BLK_W-1:0]      erase_blk,
   input  logic                  lock_set_en,
   input  logic                  lock_clr_en,
   input  logic [BLK_W-1:0]      lock_blk,
   output logic [(1<<BLK_W)-1:0] lock_q
);
   localparam int WORD_AW = ADDR_W - 1;
   localparam int NWORDS  = 1 << WORD_AW;
   localparam int NBLK    = 1 << BLK_W;

   logic [DATA_W-1:0] mem_q [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(w >> (WORD_AW - BLK_W));
      always_ff @(posedge clk) begin
         if (erase_en && erase_blk == MY_BLK)
            mem_q[w] <= '1;
         else if (prog_en && prog_widx == WORD_AW'(w))
            mem_q[w] <= mem_q[w] & prog_mask;
      end
   end

   for (genvar b = 0; b < NBLK; b++) begin : g_lock
      always_ff @(posedge clk) begin
         if (lock_clr_en)                                 lock_q[b] <= 1'b0;
         else if (lock_set_en && lock_blk == BLK_W'(b))   lock_q[b] <= 1'b1;
      end
   end

   assign rd_word = mem_q[rd_widx];

   // R4: the array is never written inside a locked block
   a_r4_prog_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |-> !lock_q[prog_widx[WORD_AW-1 -: BLK_W]]);
   a_r4_erase_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |-> !lock_q[erase_blk]);
   // R1: contents change only through an accepted operation
   a_r1_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_en && !erase_en) |=> $stable(mem_q[0]));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BLK_W     = 2,
   parameter int ERASE_CYC = 20,
   parameter int PROG_CYC  = 5,
   parameter int LOCK_CYC  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   input  logic              byte_mode,
   input  logic              vpp_ok,
   input  logic              vcc_lockout,
   output logic [15:0]       rdata
);
   localparam int DATA_W  = 16;
   localparam int WORD_AW = ADDR_W - 1;
   localparam int NBLK    = 1 << BLK_W;
   localparam int OP_MAX  = (PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC;
   localparam int CYC_MAX = (ERASE_CYC > OP_MAX) ? ERASE_CYC : OP_MAX;
   localparam int CNT_W   = $clog2(CYC_MAX + 1);

   if (BLK_W < 1 || BLK_W >= WORD_AW) begin : g_bad_blk
      $error("BLK_W must be between 1 and ADDR_W-2");
   end
   if (ERASE_CYC < 2 || PROG_CYC < 2 || LOCK_CYC < 2) begin : g_bad_cyc
      $error("operation durations must be at least 2 cycles");
   end

   fsm_e   state_q;
   rmode_e rmode_q;
   logic   susp_q, err_erase_q, err_prog_q, err_volt_q, err_lock_q, lock_clr_q;
   logic [WORD_AW-1:0] op_widx_q;
   logic [DATA_W-1:0]  op_mask_q;
   logic [BLK_W-1:0]   op_blk_q, erase_blk_q;
   logic [NBLK-1:0]    lock_q;
   logic [DATA_W-1:0]  rd_word;
   logic               erase_done, op_done;

   wire [7:0]         cmd       = wdata[7:0];
   wire               wr_ok     = vpp_ok && !vcc_lockout;
   wire [BLK_W-1:0]   addr_blk  = addr[ADDR_W-1 -: BLK_W];
   wire [WORD_AW-1:0] addr_widx = addr[ADDR_W-1:1];
   wire [DATA_W-1:0]  new_mask  = !byte_mode ? wdata :
                                  (addr[0] ? {wdata[7:0], 8'hFF} : {8'hFF, wdata[7:0]});

   wire erase_go = state_q == FS_ERASE_SETUP && we && cmd == CMD_CONFIRM
                   && wr_ok && !lock_q[addr_blk];
   wire prog_go  = state_q == FS_PROG_SETUP && we && wr_ok && !lock_q[addr_blk];
   wire lock_go  = state_q == FS_LOCK_SETUP && we && wr_ok
                   && (cmd == CMD_LOCK_SET || cmd == CMD_CONFIRM);
   wire busy     = state_q == FS_BUSY_ERASE || state_q == FS_BUSY_PROG
                   || state_q == FS_BUSY_LOCK;

   fcc_op_timer #(.CNT_W(CNT_W)) u_erase_timer (
      .clk(clk), .rst_n(rst_n), .load(erase_go), .load_val(CNT_W'(ERASE_CYC)),
      .run(state_q == FS_BUSY_ERASE), .done(erase_done));

   fcc_op_timer #(.CNT_W(CNT_W)) u_op_timer (
      .clk(clk), .rst_n(rst_n), .load(prog_go || lock_go),
      .load_val(prog_go ? CNT_W'(PROG_CYC) : CNT_W'(LOCK_CYC)),
      .run(state_q == FS_BUSY_PROG || state_q == FS_BUSY_LOCK), .done(op_done));

   fcc_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_widx(addr_widx), .rd_word(rd_word),
      .prog_en(state_q == FS_BUSY_PROG && op_done && wr_ok),
      .prog_widx(op_widx_q), .prog_mask(op_mask_q),
      .erase_en(erase_done && wr_ok), .erase_blk(erase_blk_q),
      .lock_set_en(state_q == FS_BUSY_LOCK && op_done && wr_ok && !lock_clr_q),
      .lock_clr_en(state_q == FS_BUSY_LOCK && op_done && wr_ok && lock_clr_q),
      .lock_blk(op_blk_q), .lock_q(lock_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;      rmode_q <= RM_ARRAY;    susp_q <= 1'b0;
         err_erase_q <= 1'b0;     err_prog_q <= 1'b0;
         err_volt_q <= 1'b0;      err_lock_q <= 1'b0;     lock_clr_q <= 1'b0;
         op_widx_q <= '0;         op_mask_q <= '1;
         op_blk_q <= '0;          erase_blk_q <= '0;
      end else begin
         case (state_q)
            FS_IDLE: if (we) begin
               case (cmd)
                  CMD_READ_ARRAY:   rmode_q <= RM_ARRAY;
                  CMD_READ_STATUS:  rmode_q <= RM_STATUS;
                  CMD_CLEAR_STATUS: begin
                     err_erase_q <= 1'b0; err_prog_q <= 1'b0;
                     err_volt_q  <= 1'b0; err_lock_q <= 1'b0;
                  end
                  CMD_ERASE_SETUP: if (!susp_q) begin
                     state_q <= FS_ERASE_SETUP; rmode_q <= RM_STATUS;
                  end
                  CMD_LOCK_SETUP: if (!susp_q) begin
                     state_q <= FS_LOCK_SETUP; rmode_q <= RM_STATUS;
                  end
                  CMD_PROG_SETUP: begin
                     state_q <= FS_PROG_SETUP; rmode_q <= RM_STATUS;
                  end
                  CMD_CONFIRM: if (susp_q) begin
                     susp_q <= 1'b0; state_q <= FS_BUSY_ERASE; rmode_q <= RM_STATUS;
                  end
                  default: ;
               endcase
            end
            FS_ERASE_SETUP: if (we) begin
               if (erase_go) begin
                  erase_blk_q <= addr_blk; state_q <= FS_BUSY_ERASE;
               end else begin
                  state_q <= FS_IDLE; err_erase_q <= 1'b1;
                  if (cmd != CMD_CONFIRM) err_prog_q <= 1'b1;
                  else if (!wr_ok)        err_volt_q <= 1'b1;
                  else                    err_lock_q <= 1'b1;
               end
            end
            FS_PROG_SETUP: if (we) begin
               if (prog_go) begin
                  op_widx_q <= addr_widx; op_mask_q <= new_mask;
                  state_q <= FS_BUSY_PROG;
               end else begin
                  state_q <= FS_IDLE; err_prog_q <= 1'b1;
                  if (!wr_ok) err_volt_q <= 1'b1;
                  else        err_lock_q <= 1'b1;
               end
            end
            FS_LOCK_SETUP: if (we) begin
               if (lock_go) begin
                  op_blk_q <= addr_blk; lock_clr_q <= (cmd == CMD_CONFIRM);
                  state_q <= FS_BUSY_LOCK;
               end else begin
                  state_q <= FS_IDLE;
                  if (cmd == CMD_LOCK_SET) begin
                     err_prog_q <= 1'b1; err_volt_q <= 1'b1;
                  end else if (cmd == CMD_CONFIRM) begin
                     err_erase_q <= 1'b1; err_volt_q <= 1'b1;
                  end else begin
                     err_prog_q <= 1'b1; err_erase_q <= 1'b1;
                  end
               end
            end
            FS_BUSY_ERASE: begin
               if (erase_done) begin
                  state_q <= FS_IDLE;
                  if (!wr_ok) begin err_volt_q <= 1'b1; err_erase_q <= 1'b1; end
               end else if (we && cmd == CMD_SUSPEND) begin
                  susp_q <= 1'b1; state_q <= FS_IDLE;
               end
            end
            FS_BUSY_PROG: if (op_done) begin
               state_q <= FS_IDLE;
               if (!wr_ok) begin err_volt_q <= 1'b1; err_prog_q <= 1'b1; end
            end
            FS_BUSY_LOCK: if (op_done) begin
               state_q <= FS_IDLE;
               if (!wr_ok) begin
                  err_volt_q <= 1'b1;
                  if (lock_clr_q) err_erase_q <= 1'b1;
                  else            err_prog_q  <= 1'b1;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   wire [7:0] status = {!busy, susp_q, err_erase_q, err_prog_q, err_volt_q,
                        1'b0, err_lock_q, 1'b0};
   wire [15:0] array_out = !byte_mode ? rd_word :
                           {8'h00, addr[0] ? rd_word[15:8] : rd_word[7:0]};
   assign rdata = (rmode_q == RM_STATUS) ? {8'h00, status} : array_out;

   // R10: suspending a running erase reports ready and suspended next cycle
   a_r10_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_BUSY_ERASE && !erase_done && we && cmd == CMD_SUSPEND)
      |=> (rdata[7] && rdata[6]));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n, we, byte_mode, vpp_ok, vcc_lockout;
   logic [7:0]  addr;
   logic [15:0] wdata, rdata;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   flash_cmd_ctrl i_flash_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
      .byte_mode(byte_mode), .vpp_ok(vpp_ok), .vcc_lockout(vcc_lockout),
      .rdata(rdata));

   typedef struct {
      logic [7:0]  a;
      logic        bm;
      logic [15:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t sb_q[$];

   // driver side: present a read and queue the expected value
   task automatic expect_rd(input logic [7:0] a, input logic bm,
                            input logic [15:0] exp, input string tag);
      @(negedge clk);
      addr = a; byte_mode = bm;
      sb_q.push_back('{a, bm, exp, tag});
   endtask

   // monitor side: compare after each rising edge, away from it
   always @(posedge clk) begin
      rd_item_t it;
      #2;
      if (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         n_chk++;
         if (rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [15:0] d, input logic [7:0] a, input logic bm);
      @(negedge clk);
      we = 1'b1; wdata = d; addr = a; byte_mode = bm;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic wait_ready(input string tag);
      int n = 0;
      while (n < 500) begin
         @(negedge clk);
         if (rdata[7]) break;
         n++;
      end
      n_chk++;
      if (n >= 500) begin
         n_fail++;
         $display("FAIL %s ready timeout actual=%h expected=bit7 set", tag, rdata);
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; we = 1'b0; byte_mode = 1'b0; vpp_ok = 1'b1;
      vcc_lockout = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wr(16'h0070, 8'h00, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0080, "R8 reset status");
      wr(16'h0060, 8'h00, 1'b0); wr(16'h00D0, 8'h00, 1'b0);
      wait_ready("R1 lock clear");
      for (int b = 0; b < 4; b++) begin
         wr(16'h0020, 8'(b * 64), 1'b0); wr(16'h00D0, 8'(b * 64), 1'b0);
         wait_ready("R7 initial erase");
      end
      expect_rd(8'h10, 1'b0, 16'h0080, "R11 status held after erase");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h10, 1'b0, 16'hFFFF, "R7 erased word");

      // program word, busy flag, read modes, lanes
      wr(16'h0040, 8'h10, 1'b0); wr(16'h1234, 8'h10, 1'b0);
      expect_rd(8'h10, 1'b0, 16'h0000, "R8 busy while programming");
      wait_ready("R8 program end");
      expect_rd(8'h10, 1'b0, 16'h0080, "R11 status until read array");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h10, 1'b0, 16'h1234, "R12 word read");
      expect_rd(8'h11, 1'b0, 16'h1234, "R12 addr0 ignored in word mode");
      expect_rd(8'h10, 1'b1, 16'h0034, "R12 byte low lane");
      expect_rd(8'h11, 1'b1, 16'h0012, "R12 byte high lane");

      // latched program, byte lane, AND
      wr(16'h0040, 8'h21, 1'b1); wr(16'h000F, 8'h21, 1'b1);
      addr = 8'h10; wdata = 16'h0000; byte_mode = 1'b0;
      wait_ready("R6 byte program end");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h20, 1'b0, 16'h0FFF, "R6 byte program latched");
      expect_rd(8'h10, 1'b0, 16'h1234, "R6 bus change ignored");
      wr(16'h0040, 8'h20, 1'b0); wr(16'hF0F0, 8'h20, 1'b0);
      wait_ready("R6 and program end");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h20, 1'b0, 16'h00F0, "R6 program ANDs");

      // lone confirm codes
      wr(16'h00D0, 8'h10, 1'b0); wr(16'h0001, 8'h10, 1'b0);
      expect_rd(8'h10, 1'b0, 16'h1234, "R1 lone confirm ignored");
      wr(16'h0070, 8'h00, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0080, "R1 status untouched");

      // bad second cycle, clear status
      wr(16'h0020, 8'h10, 1'b0); wr(16'h00FF, 8'h10, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h00B0, "R2 sequence error");
      wr(16'h0050, 8'h00, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0080, "R9 clear status");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h10, 1'b0, 16'h1234, "R2 no alteration");

      // protection inputs
      vpp_ok = 1'b0;
      wr(16'h0040, 8'h12, 1'b0); wr(16'h0000, 8'h12, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0098, "R3 program enable low");
      vpp_ok = 1'b1;
      wr(16'h0050, 8'h00, 1'b0);
      vcc_lockout = 1'b1;
      wr(16'h0020, 8'h40, 1'b0); wr(16'h00D0, 8'h40, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h00A8, "R3 supply lockout erase");
      vcc_lockout = 1'b0;
      wr(16'h0050, 8'h00, 1'b0);
      wr(16'h0040, 8'h14, 1'b0); wr(16'h0000, 8'h14, 1'b0);
      vpp_ok = 1'b0;
      wait_ready("R3 drop end");
      vpp_ok = 1'b1;
      expect_rd(8'h00, 1'b0, 16'h0098, "R3 enable lost during program");
      wr(16'h0050, 8'h00, 1'b0); wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h12, 1'b0, 16'hFFFF, "R3 word 0x12 unchanged");
      expect_rd(8'h14, 1'b0, 16'hFFFF, "R3 word 0x14 unchanged");

      // lock bits
      wr(16'h0060, 8'h80, 1'b0); wr(16'h0001, 8'h80, 1'b0);
      wait_ready("R4 lock set");
      wr(16'h0040, 8'h80, 1'b0); wr(16'h0000, 8'h80, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0092, "R4 program locked block");
      wr(16'h0050, 8'h00, 1'b0);
      wr(16'h0020, 8'h80, 1'b0); wr(16'h00D0, 8'h80, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h00A2, "R4 erase locked block");
      wr(16'h0050, 8'h00, 1'b0); wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h80, 1'b0, 16'hFFFF, "R4 locked word unchanged");
      wr(16'h0060, 8'h00, 1'b0); wr(16'h00D0, 8'h00, 1'b0);
      wait_ready("R4 lock clear");
      wr(16'h0040, 8'h80, 1'b0); wr(16'h5555, 8'h80, 1'b0);
      wait_ready("R4 program after clear");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h80, 1'b0, 16'h5555, "R4 program after unlock");

      // erase suspend and resume
      wr(16'h0040, 8'hC0, 1'b0); wr(16'h0000, 8'hC0, 1'b0);
      wait_ready("R10 preload");
      wr(16'h0020, 8'hC0, 1'b0); wr(16'h00D0, 8'hC0, 1'b0);
      repeat (3) @(negedge clk);
      wr(16'h00B0, 8'h00, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h00C0, "R10 suspended status");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h80, 1'b0, 16'h5555, "R10 read other block");
      expect_rd(8'hC0, 1'b0, 16'h0000, "R10 erase not finished");
      wr(16'h0040, 8'h82, 1'b0); wr(16'hAAAA, 8'h82, 1'b0);
      wait_ready("R10 program in suspend");
      expect_rd(8'h00, 1'b0, 16'h00C0, "R10 still suspended");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'h82, 1'b0, 16'hAAAA, "R10 program during suspend");
      wr(16'h00D0, 8'h00, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0000, "R10 resumed busy");
      wait_ready("R10 erase end");
      expect_rd(8'h00, 1'b0, 16'h0080, "R10 erase done status");
      wr(16'h00FF, 8'h00, 1'b0);
      expect_rd(8'hC0, 1'b0, 16'hFFFF, "R7 target erased");
      expect_rd(8'hFE, 1'b0, 16'hFFFF, "R7 block end erased");
      expect_rd(8'h80, 1'b0, 16'h5555, "R7 other block kept");
      expect_rd(8'h82, 1'b0, 16'hAAAA, "R7 other block kept 2");

      // reset aborts
      wr(16'h0040, 8'h16, 1'b0); wr(16'h0000, 8'h16, 1'b0);
      @(negedge clk);
      rst_n = 1'b0; we = 1'b1; wdata = 16'h0020; addr = 8'h16;
      repeat (2) @(negedge clk);
      we = 1'b0; rst_n = 1'b1;
      expect_rd(8'h16, 1'b0, 16'hFFFF, "R5 aborted program no change");
      wr(16'h0070, 8'h00, 1'b0);
      expect_rd(8'h00, 1'b0, 16'h0080, "R5 status after reset");

      repeat (4) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule